// File: doc/BRIEF.md
# Banked Register File Address Decoder

This block turns the 7-bit register offset carried by an instruction into a physical location in a data memory built from four banks of 128 bytes each. The bank is picked by a two-bit field inside a status byte that the block holds itself. Code changes the bank by writing that status byte, which lives at a fixed offset. Each offset is classified as belonging either to the low special-function area or to general-purpose RAM. A small, parameterised set of heavily used special-function offsets, the status byte among them, is mirrored: these offsets resolve to the same physical byte whichever bank is selected.

The decode path is purely combinational from the offset and the held bank field. The block also holds the backing storage, so software-visible behaviour (independent banks, shared mirrored bytes) can be observed at the ports. The control pins are plain strobes. A write strobe commits at the clock edge. A read strobe returns its byte one cycle later with a valid flag. There is no back-pressure: every strobe is accepted in the cycle it is raised.

Top module: `brf_decoder`

## Requirements
- R1: The bank field is bits 6 and 5 of the status byte. The value 0, 1, 2 or 3 selects bank 0, 1, 2 or 3, and `bank_sel` always shows the field currently held.
- R2: For an offset that is not mirrored, `phys_addr` equals the bank field in bits 8:7 concatenated with the offset in bits 6:0.
- R3: `is_sfr` is high exactly when the offset is below 20h. Offsets 20h to 7Fh are general-purpose RAM.
- R4: Offsets 02h, 03h, 04h, 0Ah and 0Bh are mirrored. For these, `is_mirror` is high and `phys_addr` is the bank-0 address (upper two bits zero), whatever the bank field is.
- R5: The status byte sits at offset 03h. Writing it loads all eight bits at the clock edge. The new bank field governs the next access and not the access that carries the write.
- R6: A read strobe makes `rd_valid` high in the following cycle, with `rd_data` holding the byte at the decoded physical address. Without a read strobe, `rd_valid` is low in the next cycle.
- R7: When a read and a write hit the same location in one cycle, the read returns the content from before the write, and the write takes effect.
- R8: General-purpose bytes at the same offset in different banks are separate storage, while a mirrored byte written through any bank reads back identically through every bank.
- R9: After reset the status byte is 18h, so the bank is 0, and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe for the current offset |
| wr_en | input | 1 | Write strobe for the current offset |
| offset | input | 7 | Register offset inside the bank |
| wdata | input | 8 | Write data |
| bank_sel | output | 2 | Bank field currently held in the status byte |
| phys_addr | output | 9 | Decoded physical address |
| is_sfr | output | 1 | High when the offset is in the special-function area |
| is_mirror | output | 1 | High when the offset is mirrored across banks |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 8 | Read data |

## Verification
Two things can happen in the same cycle: a write to the status byte that changes the bank, and the decoding of that same access, which must still use the old bank. The bench provokes this with a combined read and write on offset 03h. It expects the decoded address and `bank_sel` to show the old bank during that cycle, and expects the read to return the old status byte. The following access is then expected to decode in the new bank. A behavioural model, held as plain integer arrays, predicts every output on every cycle and judges the result.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int OFS_W  = 7;
  localparam int BANK_W = 2;
  localparam int DATA_W = 8;
  localparam int PHYS_W = OFS_W + BANK_W;

  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [PHYS_W-1:0] phys_t;
endpackage

// File: rtl/brf_addr_map.sv
module brf_addr_map
  import brf_pkg::*;
#(
  parameter int          SFR_SPAN    = 32,
  parameter logic [31:0] MIRROR_MASK = 32'h0000_0C1C
) (
  input  ofs_t  offset,
  input  bank_t bank,
  output phys_t phys,
  output logic  is_sfr,
  output logic  is_mirror
);
  localparam ofs_t SFR_LIMIT = ofs_t'(SFR_SPAN);

  logic [SFR_SPAN-1:0] mir_hit;

  for (genvar g = 0; g < SFR_SPAN; g++) begin : g_mirror
    if (MIRROR_MASK[g]) begin : g_on
      assign mir_hit[g] = (offset == ofs_t'(g));
    end else begin : g_off
      assign mir_hit[g] = 1'b0;
    end
  end

  always_comb begin
    is_sfr    = (offset < SFR_LIMIT);
    is_mirror = |mir_hit;
    phys      = is_mirror ? {{BANK_W{1'b0}}, offset} : {bank, offset};
  end
endmodule

// File: rtl/brf_bank_reg.sv
module brf_bank_reg
  import brf_pkg::*;
#(
  parameter byte_t STATUS_RST = 8'h18,
  parameter int    BANK_LSB   = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t wdata,
  output byte_t status,
  output bank_t bank
);
  byte_t status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    status_q <= STATUS_RST;
    else if (load) status_q <= wdata;
  end

  assign status = status_q;
  assign bank   = status_q[BANK_LSB +: BANK_W];

  p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank));
  p_bank_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bank == $past(wdata[BANK_LSB +: BANK_W])));
endmodule

// File: rtl/brf_store.sv
module brf_store
  import brf_pkg::*;
(
  input  logic  clk,
  input  logic  wr_en,
  input  logic  rd_en,
  input  phys_t phys,
  input  byte_t wdata,
  output byte_t rd_data
);
  localparam int NBANK = 1 << BANK_W;
  localparam int DEPTH = 1 << OFS_W;

  bank_t bsel;
  ofs_t  row;
  byte_t bank_rd [NBANK];
  byte_t rd_q;

  assign bsel = phys[PHYS_W-1 -: BANK_W];
  assign row  = phys[OFS_W-1:0];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    byte_t mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (bsel == bank_t'(g))) mem[row] <= wdata;
    end
    assign bank_rd[g] = mem[row];
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= bank_rd[bsel];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/brf_decoder.sv
module brf_decoder
  import brf_pkg::*;
#(
  parameter int          SFR_SPAN    = 32,
  parameter logic [31:0] MIRROR_MASK = 32'h0000_0C1C,
  parameter int          STATUS_OFS  = 3,
  parameter logic [7:0]  STATUS_RST  = 8'h18,
  parameter int          BANK_LSB    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [6:0] offset,
  input  logic [7:0] wdata,
  output logic [1:0] bank_sel,
  output logic [8:0] phys_addr,
  output logic       is_sfr,
  output logic       is_mirror,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  localparam phys_t STATUS_PHYS = phys_t'(STATUS_OFS);

  bank_t bank;
  byte_t status;
  phys_t phys;
  logic  status_hit;
  byte_t store_rd;
  logic  rv_q;
  logic  sel_status_q;
  byte_t status_snap_q;

  brf_addr_map #(
    .SFR_SPAN   (SFR_SPAN),
    .MIRROR_MASK(MIRROR_MASK)
  ) u_map (
    .offset   (offset),
    .bank     (bank),
    .phys     (phys),
    .is_sfr   (is_sfr),
    .is_mirror(is_mirror)
  );

  assign status_hit = (phys == STATUS_PHYS);

  brf_bank_reg #(
    .STATUS_RST(STATUS_RST),
    .BANK_LSB  (BANK_LSB)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_en && status_hit),
    .wdata (wdata),
    .status(status),
    .bank  (bank)
  );

  brf_store u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .phys   (phys),
    .wdata  (wdata),
    .rd_data(store_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q          <= 1'b0;
      sel_status_q  <= 1'b0;
      status_snap_q <= '0;
    end else begin
      rv_q <= rd_en;
      if (rd_en) begin
        sel_status_q  <= status_hit;
        status_snap_q <= status;
      end
    end
  end

  assign bank_sel  = bank;
  assign phys_addr = phys;
  assign rd_valid  = rv_q;
  assign rd_data   = sel_status_q ? status_snap_q : store_rd;

  p_phys_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFS_W-1:0] == offset);
  p_nonmirror_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mirror |-> (phys_addr[PHYS_W-1 -: BANK_W] == bank_sel));
  p_mirror_sfr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_mirror |-> (is_sfr && phys_addr[PHYS_W-1 -: BANK_W] == '0));
  p_rd_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_no_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: tb/sim_brf_decoder.sv
module sim_brf_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] offset = '0;
  logic [7:0] wdata = '0;
  logic [1:0] bank_sel;
  logic [8:0] phys_addr;
  logic       is_sfr, is_mirror, rd_valid;
  logic [7:0] rd_data;

  int n_run = 0;
  int n_fail = 0;

  int ref_mem [512];
  int ref_status = 8'h18;
  int exp_rv = 0;
  int exp_rd = 0;
  string exp_tag = "R6";

  always #10 clk = ~clk;

  brf_decoder u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .offset(offset), .wdata(wdata), .bank_sel(bank_sel),
    .phys_addr(phys_addr), .is_sfr(is_sfr), .is_mirror(is_mirror),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit mirrored(input int off);
    return (off == 2) || (off == 3) || (off == 4) || (off == 10) || (off == 11);
  endfunction

  function automatic int phys_of(input int off);
    if (mirrored(off)) return off;
    return ((ref_status >> 5) & 3) * 128 + off;
  endfunction

  task automatic step(input bit rd, input bit wr, input int off, input int wd,
                      input string tag);
    int p;
    @(negedge clk);
    rd_en = rd; wr_en = wr; offset = 7'(off); wdata = 8'(wd);
    #8;
    check("R6 rd_valid", int'(rd_valid), exp_rv);
    if (exp_rv != 0) check({exp_tag, " rd_data"}, int'(rd_data), exp_rd);
    p = phys_of(off);
    check("R2/R4 phys_addr", int'(phys_addr), p);
    check("R3 is_sfr", int'(is_sfr), (off < 32) ? 1 : 0);
    check("R4 is_mirror", int'(is_mirror), mirrored(off) ? 1 : 0);
    check("R1 bank_sel", int'(bank_sel), (ref_status >> 5) & 3);
    @(posedge clk);
    exp_rv = rd;
    exp_tag = tag;
    if (rd) exp_rd = (p == 3) ? ref_status : ref_mem[p];
    if (wr) begin
      if (p == 3) ref_status = wd & 8'hFF;
      else ref_mem[p] = wd & 8'hFF;
    end
  endtask

  function automatic int val_of(input int b, input int off);
    return ((b * 61) + (off * 7) + 8'h5A) & 8'hFF;
  endfunction

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 rd_valid at reset", int'(rd_valid), 0);
    check("R9 bank_sel at reset", int'(bank_sel), 0);
    rst_n = 1'b1;
    step(1, 0, 3, 0, "R9");
    step(0, 0, 0, 0, "R9");

    for (int b = 0; b < 4; b++) begin
      step(0, 1, 3, b << 5, "R5");
      for (int off = 0; off < 128; off++)
        if (off != 3) step(0, 1, off, val_of(b, off), "R8");
    end

    for (int b = 0; b < 4; b++) begin
      step(0, 1, 3, (b << 5) | 8'h01, "R5");
      step(0, 0, 0, 0, "R1");
      check("R1 bank encoding", int'(bank_sel), b);
      for (int off = 0; off < 128; off++)
        if (off != 3) step(1, 0, off, 0, "R8");
    end

    step(0, 1, 3, 8'h00, "R5");
    step(1, 1, 3, 8'h40, "R5 old status on same-cycle write");
    step(1, 0, 8'h40, 0, "R5");
    check("R5 new bank on next access", int'(phys_addr), 9'h140);
    step(1, 0, 3, 0, "R5");

    step(1, 1, 8'h30, 8'hA5, "R7 read-before-write");
    step(1, 0, 8'h30, 0, "R7 written value");
    step(1, 1, 8'h0A, 8'h3C, "R7 mirrored read-before-write");
    step(0, 1, 3, 8'h60, "R5");
    step(1, 0, 8'h0A, 0, "R8 mirrored across banks");
    step(1, 0, 8'h30, 0, "R8 bank independence");
    step(0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, "R6");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule